// File: doc/BRIEF.md
# Trap Entry and Interrupt Arbitration Unit

This unit owns the supervisor status word of a simple in-order core and decides, once per cycle, whether the core must leave its current instruction stream. A synchronous exception raised by the pipeline always wins. Without one, the unit takes the lowest-numbered interrupt line that is pending, unmasked and globally enabled. On every trap it saves the faulting PC and the cause code. It moves the old privilege and enable bits into their "previous" slots, enters supervisor mode with interrupts off, tells the load/store side to drop any load reservation, and presents the trap vector as the next fetch address.

All outputs are registered, so a trap accepted at one rising edge is visible at the ports during the following cycle. The exception request has no back-pressure: the unit accepts every request in the cycle it is presented, so no ready signal exists. The status word can also be written through a plain write strobe, which is how software opens the interrupt mask and sets the enable bit.

Status word layout (width 8 + NIRQ): bit 0 supervisor, bit 1 previous supervisor, bit 2 interrupt enable, bit 3 previous interrupt enable, bit 4 supervisor 64-bit mode, bit 5 user 64-bit mode, bits 6 and 7 always zero, bit 8+i mask for interrupt line i.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt line i can cause a trap only when irq_pending[i], status mask bit 8+i and status bit 2 (enable) are all 1. Otherwise no redirect occurs.
- R2: When several lines qualify in one cycle, the lowest index is taken, and the cause low bits hold that index.
- R3: An interrupt cause is the line index with one extra bit set: bit XLEN-1 when status bit 4 is 1, bit 31 when it is 0. All other cause bits are zero.
- R4: After a trap, status bit 0 is 1 and status bit 2 is 0. Bits 4, 5 and the mask are unchanged.
- R5: After a trap, status bit 1 holds the pre-trap bit 0, and status bit 3 holds the pre-trap bit 2.
- R6: A trap accepted at an edge gives redirect_valid=1 for the next cycle only (unless another trap is taken), with redirect_pc equal to evec and epc_q equal to cur_pc as sampled at that edge.
- R7: resv_clear is 1 in exactly the cycles in which redirect_valid is 1.
- R8: After reset, status_q is 0x31, redirect_pc is 0x2000, redirect_valid and resv_clear are 0, and cause_q, epc_q and badaddr_q are 0.
- R9: When exc_valid is 1, the trap is the exception with cause_q = exc_cause, even if an interrupt also qualifies.
- R10: badaddr_q loads exc_addr only on an exception with exc_has_addr=1. Otherwise it keeps its value.
- R11: sr_wr_en loads sr_wr_data with bits 6, 7 and any bit above the mask forced to zero. The write is ignored in a cycle in which a trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception request this cycle |
| exc_cause | input | XLEN | Cause code of the exception |
| exc_has_addr | input | 1 | Exception carries a faulting address |
| exc_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the instruction being retired or trapped |
| irq_pending | input | NIRQ | Level-sensitive pending interrupt lines |
| evec | input | XLEN | Trap vector register value |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 8+NIRQ | Status word write data |
| status_q | output | 8+NIRQ | Current status word |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Trap target address |
| cause_q | output | XLEN | Cause register |
| epc_q | output | XLEN | Exception PC register |
| badaddr_q | output | XLEN | Faulting address register |
| resv_clear | output | 1 | Drop any outstanding load reservation |

## Verification
The embedded properties assume that every input is a known value at each rising edge once reset is released. They do not assume that exceptions, interrupts and status writes are kept apart. The stimulus drives all inputs just after a falling edge, so they are settled well before the next rising edge. Directed sequences place an exception, a qualifying interrupt and a status write in the same cycle. The random phase draws every input freely and never leaves an input undriven. A behavioural reference model in the bench is compared with all outputs on every falling edge.

// File: rtl/tu_pkg.sv
package tu_pkg;
  // Status word field positions
  localparam int ST_SUP     = 0;
  localparam int ST_PSUP    = 1;
  localparam int ST_IEN     = 2;
  localparam int ST_PIEN    = 3;
  localparam int ST_SUP64   = 4;
  localparam int ST_USR64   = 5;
  localparam int ST_IM_LSB  = 8;

  // Status value at reset, excluding the mask: supervisor, both 64-bit modes
  localparam logic [7:0] ST_RESET_LOW = 8'h31;
  // Writable bits of the low byte
  localparam logic [7:0] ST_WR_LOW    = 8'h3F;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_IRQ  = 2'd2
  } trap_src_e;
endpackage

// File: rtl/tu_irq_select.sv
module tu_irq_select #(
  parameter int NIRQ = 8,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pending,
  input  logic [NIRQ-1:0] mask,
  input  logic            enable,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic [NIRQ-1:0] grant
);
  logic [NIRQ-1:0] req;
  logic [NIRQ:0]   seen;   // seen[i]: some lower line already requested

  assign req     = pending & mask & {NIRQ{enable}};
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_chain
      assign grant[g]  = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
    end
  endgenerate

  assign hit = seen[NIRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (grant[i]) idx = idx | IDXW'(i);
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("more than one grant"); // R2

  AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (enable && ((pending & mask) != '0))) else $error("unqualified grant"); // R1

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((pending & mask) & ~({NIRQ{1'b1}} << idx)) == '0)) else $error("lower line skipped"); // R2
endmodule

// File: rtl/tu_status_reg.sv
module tu_status_reg #(
  parameter int NIRQ = 8,
  localparam int SRW = tu_pkg::ST_IM_LSB + NIRQ
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           wr_en,
  input  logic [SRW-1:0] wr_data,
  output logic [SRW-1:0] status_q
);
  import tu_pkg::*;

  localparam logic [SRW-1:0] WR_MASK  = {{NIRQ{1'b1}}, ST_WR_LOW};
  localparam logic [SRW-1:0] RST_VAL  = {{NIRQ{1'b0}}, ST_RESET_LOW};

  logic [SRW-1:0] entered;

  always_comb begin
    entered           = status_q;
    entered[ST_SUP]   = 1'b1;
    entered[ST_IEN]   = 1'b0;
    entered[ST_PSUP]  = status_q[ST_SUP];
    entered[ST_PIEN]  = status_q[ST_IEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= RST_VAL;
    else if (take)  status_q <= entered;
    else if (wr_en) status_q <= wr_data & WR_MASK;
  end

  AST_ENTER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status_q[ST_SUP] && !status_q[ST_IEN])) else $error("trap mode wrong"); // R4

  AST_PREV_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status_q[ST_PSUP] == $past(status_q[ST_SUP]) &&
              status_q[ST_PIEN] == $past(status_q[ST_IEN]))) else $error("prev bits lost"); // R5

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $stable(status_q[SRW-1:ST_SUP64])) else $error("mode/mask changed on trap"); // R4

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !wr_en) |=> $stable(status_q)) else $error("status changed spontaneously"); // R11

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:6] == 2'b00) else $error("reserved status bits set"); // R11
endmodule

// File: rtl/tu_trap_regs.sv
module tu_trap_regs #(
  parameter int          XLEN     = 64,
  parameter logic [63:0] RESET_PC = 64'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] cause_nxt,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] evec,
  input  logic            bad_we,
  input  logic [XLEN-1:0] bad_addr,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badaddr_q,
  output logic            resv_clear
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      resv_clear     <= 1'b0;
      redirect_pc    <= RESET_PC[XLEN-1:0];
      cause_q        <= '0;
      epc_q          <= '0;
    end else begin
      redirect_valid <= take;
      resv_clear     <= take;
      if (take) begin
        redirect_pc <= evec;
        cause_q     <= cause_nxt;
        epc_q       <= cur_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      badaddr_q <= '0;
    else if (bad_we) badaddr_q <= bad_addr;
  end

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redirect_valid && redirect_pc == $past(evec) && epc_q == $past(cur_pc)))
    else $error("redirect target or epc wrong"); // R6

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !redirect_valid) else $error("redirect without trap"); // R6

  AST_RESV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> resv_clear) else $error("reservation kept across trap"); // R7

  AST_BADADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_we |=> $stable(badaddr_q)) else $error("badaddr changed"); // R10
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int          XLEN     = 64,
  parameter int          NIRQ     = 8,
  parameter logic [63:0] RESET_PC = 64'h2000,
  localparam int         SRW      = tu_pkg::ST_IM_LSB + NIRQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [XLEN-1:0] exc_cause,
  input  logic            exc_has_addr,
  input  logic [XLEN-1:0] exc_addr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [NIRQ-1:0] irq_pending,
  input  logic [XLEN-1:0] evec,
  input  logic            sr_wr_en,
  input  logic [SRW-1:0]  sr_wr_data,
  output logic [SRW-1:0]  status_q,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badaddr_q,
  output logic            resv_clear
);
  import tu_pkg::*;

  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            irq_hit;
  logic [IDXW-1:0] irq_idx;
  logic [NIRQ-1:0] irq_grant;
  trap_src_e       src;
  logic            take;
  logic [XLEN-1:0] irq_cause;
  logic [XLEN-1:0] cause_nxt;

  tu_irq_select #(.NIRQ(NIRQ)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (irq_pending),
    .mask    (status_q[SRW-1:ST_IM_LSB]),
    .enable  (status_q[ST_IEN]),
    .hit     (irq_hit),
    .idx     (irq_idx),
    .grant   (irq_grant)
  );

  // Exception outranks any qualifying interrupt
  always_comb begin
    if (exc_valid)    src = SRC_EXC;
    else if (irq_hit) src = SRC_IRQ;
    else              src = SRC_NONE;
  end

  assign take = (src != SRC_NONE);

  always_comb begin
    irq_cause              = '0;
    irq_cause[IDXW-1:0]    = irq_idx;
    if (status_q[ST_SUP64]) irq_cause[XLEN-1] = 1'b1;
    else                    irq_cause[31]     = 1'b1;
  end

  assign cause_nxt = (src == SRC_EXC) ? exc_cause : irq_cause;

  tu_status_reg #(.NIRQ(NIRQ)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .wr_en    (sr_wr_en),
    .wr_data  (sr_wr_data),
    .status_q (status_q)
  );

  tu_trap_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take),
    .cause_nxt      (cause_nxt),
    .cur_pc         (cur_pc),
    .evec           (evec),
    .bad_we         (exc_valid & exc_has_addr),
    .bad_addr       (exc_addr),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .cause_q        (cause_q),
    .epc_q          (epc_q),
    .badaddr_q      (badaddr_q),
    .resv_clear     (resv_clear)
  );

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (redirect_valid && cause_q == $past(exc_cause))) else $error("exception lost"); // R9

  AST_IRQ_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && irq_grant != '0) |=> (cause_q[XLEN-1] || cause_q[31])) else $error("irq cause flag missing"); // R3

  AST_NO_TRAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !status_q[ST_IEN]) |=> !redirect_valid) else $error("trap while disabled"); // R1
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam int XLEN = 64;
  localparam int NIRQ = 8;
  localparam int SRW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            exc_valid = 1'b0;
  logic [XLEN-1:0] exc_cause = '0;
  logic            exc_has_addr = 1'b0;
  logic [XLEN-1:0] exc_addr = '0;
  logic [XLEN-1:0] cur_pc = '0;
  logic [NIRQ-1:0] irq_pending = '0;
  logic [XLEN-1:0] evec = '0;
  logic            sr_wr_en = 1'b0;
  logic [SRW-1:0]  sr_wr_data = '0;
  logic [SRW-1:0]  status_q;
  logic            redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] badaddr_q;
  logic            resv_clear;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_has_addr(exc_has_addr), .exc_addr(exc_addr), .cur_pc(cur_pc),
    .irq_pending(irq_pending), .evec(evec), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .status_q(status_q), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .cause_q(cause_q), .epc_q(epc_q),
    .badaddr_q(badaddr_q), .resv_clear(resv_clear)
  );

  // Behavioural reference model
  logic [15:0] m_status;
  logic        m_rv, m_resv;
  logic [63:0] m_rpc, m_cause, m_epc, m_bad;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = 16'h0031; m_rv = 0; m_resv = 0;
      m_rpc = 64'h2000; m_cause = 0; m_epc = 0; m_bad = 0;
    end else begin
      int pick;
      bit trap;
      pick = -1;
      if (m_status[2])
        for (int i = NIRQ - 1; i >= 0; i--)
          if (irq_pending[i] && m_status[8 + i]) pick = i;
      trap = exc_valid || (pick >= 0);
      if (exc_valid) begin
        m_cause = exc_cause;
        if (exc_has_addr) m_bad = exc_addr;
      end else if (pick >= 0) begin
        m_cause = 64'(pick) | (m_status[4] ? (64'd1 << 63) : (64'd1 << 31));
      end
      if (trap) begin
        m_status[1] = m_status[0];
        m_status[3] = m_status[2];
        m_status[0] = 1'b1;
        m_status[2] = 1'b0;
        m_epc = cur_pc;
        m_rpc = evec;
      end else if (sr_wr_en) begin
        m_status = sr_wr_data & 16'hFF3F;
      end
      m_rv = trap;
      m_resv = trap;
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 redirect_valid", 64'(redirect_valid), 64'(m_rv));
    chk("R6 redirect_pc", redirect_pc, m_rpc);
    chk("R3/R6/R9 cause", cause_q, m_cause);
    chk("R6 epc", epc_q, m_epc);
    chk("R10 badaddr", badaddr_q, m_bad);
    chk("R4/R5/R11 status", 64'(status_q), 64'(m_status));
    chk("R7 resv_clear", 64'(resv_clear), 64'(m_resv));
  endtask

  task automatic idle();
    exc_valid = 0; exc_has_addr = 0; sr_wr_en = 0; irq_pending = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr_status(logic [15:0] v);
    idle(); sr_wr_en = 1; sr_wr_data = v; cyc(); sr_wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    evec = 64'h8000_0100; cur_pc = 64'h1000;
    @(negedge clk);
    // R8: reset values
    chk("R8 status reset", 64'(status_q), 64'h31);
    chk("R8 redirect_pc reset", redirect_pc, 64'h2000);
    chk("R8 redirect_valid reset", 64'(redirect_valid), 64'h0);
    compare_all();

    // R1: masked lines and disabled enable give no trap
    wr_status(16'h0035);
    idle(); irq_pending = 8'hFF; cyc();
    chk("R1 all masked", 64'(redirect_valid), 64'h0);
    wr_status(16'hFF31);
    idle(); irq_pending = 8'hFF; cyc();
    chk("R1 enable clear", 64'(redirect_valid), 64'h0);

    // R2: lowest qualifying line, R5: previous bits
    wr_status(16'h0C35);
    idle(); irq_pending = 8'h0E; cur_pc = 64'h1234; cyc();
    chk("R2 lowest index", cause_q, 64'h8000_0000_0000_0002);
    chk("R5 status after irq", 64'(status_q), 64'h0C3B);
    chk("R7 resv on irq", 64'(resv_clear), 64'h1);
    idle(); cyc();
    chk("R6 single pulse", 64'(redirect_valid), 64'h0);

    // R3: 32-bit supervisor mode puts flag at bit 31
    wr_status(16'h0C25);
    idle(); irq_pending = 8'h08; cyc();
    chk("R3 bit31 flag", cause_q, 64'h0000_0000_8000_0003);

    // R9: exception and interrupt together
    wr_status(16'h0C35);
    idle(); irq_pending = 8'h04; exc_valid = 1; exc_cause = 64'd5; cyc();
    chk("R9 exception wins", cause_q, 64'd5);

    // R10: bad address only with flag
    idle(); exc_valid = 1; exc_cause = 64'd4; exc_has_addr = 1; exc_addr = 64'hDEAD; cyc();
    chk("R10 badaddr load", badaddr_q, 64'hDEAD);
    idle(); exc_valid = 1; exc_cause = 64'd2; exc_addr = 64'hBEEF; cyc();
    chk("R10 badaddr kept", badaddr_q, 64'hDEAD);

    // R11: write ignored under trap, reserved bits zero
    idle(); exc_valid = 1; sr_wr_en = 1; sr_wr_data = 16'h0000; cyc();
    chk("R11 write ignored on trap", 64'(status_q[0]), 64'h1);
    wr_status(16'hFFFF);
    chk("R11 reserved bits zero", 64'(status_q), 64'hFF3F);

    // Random phase
    for (int n = 0; n < 600; n++) begin
      idle();
      exc_valid    = ($urandom_range(0, 4) == 0);
      exc_cause    = {$urandom, $urandom};
      exc_has_addr = $urandom_range(0, 1);
      exc_addr     = {$urandom, $urandom};
      cur_pc       = {$urandom, $urandom};
      evec         = {$urandom, $urandom};
      irq_pending  = NIRQ'($urandom);
      sr_wr_en     = ($urandom_range(0, 3) == 0);
      sr_wr_data   = SRW'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R6 got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule